// File: doc/BRIEF.md
# Pointer-Readback Serial Register Slave

This block is a serial register bank that a host programs and reads over a three-wire style link: a serial clock, a serial data line and a frame-enable strobe. The strobe is held low for the whole of a transfer and is raised to close it. Each transfer carries a 32-bit word sent most significant bit first. The top 24 bits are the payload. The next 5 bits name the target register. The last 3 bits are a chip select code. When the strobe rises, the payload is written into the bank, provided that exactly 32 serial clock edges were seen and the chip code matches.

There is no read command. Register 0 doubles as a read pointer: its low five bits name a register. On the next transfer, that register is shifted out on a shared output pin while the host shifts in new data. Outside a transfer the same pin passes through a lock status input. To read an arbitrary register, the host writes the pointer in one transfer and collects the data in the following one. A common choice for that second transfer is to write register 0 again with the same value.

All serial inputs are brought into the system clock domain through synchronizer chains, and their edges are detected there. The serial clock must therefore be several system clocks slower than the system clock.

Top module: `ptr_spi_slave`

## Requirements
- R1: After reset, every register in the bank reads as zero. The pointer is therefore 0, and the output pin shows the lock input while no frame is open.
- R2: A frame is the strobe held low, with the data bit sampled on each rising serial clock edge, most significant bit first. Frame bits 31..8 are the payload, bits 7..3 are the register address, and bits 2..0 are the chip code. The payload is written to the addressed register when the strobe rises.
- R3: A frame whose chip code is any value other than 000 writes nothing.
- R4: A frame that saw fewer or more than 32 rising serial clock edges before the strobe rose writes nothing.
- R5: Bits 4..0 of register 0 are the read pointer. The register they name is returned during the next frame.
- R6: During a frame, the output pin starts with bit 23 of the selected register. It steps to the next lower bit after each rising serial clock edge. After 24 edges it shows 0 for the rest of the frame.
- R7: While no frame is open, the output pin equals the lock input. While a frame is open, the lock input has no effect on the pin.
- R8: Until register 0 is written again, every frame returns the register named by the same pointer.
- R9: The pointer is captured when a frame opens. A frame that writes register 0 still returns the register named by the old pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data from host |
| frame_en_i | input | 1 | Frame strobe, low while a frame is open, rising edge commits |
| lock_i | input | 1 | Lock status shown on the pin between frames |
| sdo_o | output | 1 | Shared output: read data in a frame, lock status otherwise |

## Verification
A corrupted bank entry or pointer stays hidden until the next frame that selects it. The bench therefore sets the pointer to every register in turn and reads each one in the following frame, so that any wrong entry appears within two frames as a wrong bit on the pin. Frames with a wrong bit count or a wrong chip code are always followed by readbacks. An unwanted write then shows as a changed pointer or changed data one frame later. A read shifter that does not zero-fill or is not aligned shows up on the very next serial clock edge. A bad pin multiplexer shows up within one system clock, because the lock input is driven to the opposite of the expected data bit throughout every frame.

// File: rtl/ptrspi_pkg.sv
package ptrspi_pkg;
  localparam int DEF_DATA_W  = 24;
  localparam int DEF_ADDR_W  = 5;
  localparam int DEF_CHIP_W  = 3;
  localparam int DEF_CHIP_ID = 0;
  localparam int DEF_SYNC    = 2;
  // bit positions inside the synchronizer vector
  localparam int SYN_SCLK = 0;
  localparam int SYN_SDI  = 1;
  localparam int SYN_EN   = 2;
  localparam int SYN_W    = 3;
endpackage

// File: rtl/ptrspi_sync.sv
module ptrspi_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      always_comb stage_d = d_i;
    end else begin : g_next
      always_comb stage_d = chain_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= RST_VAL;
      else        chain_q[s] <= stage_d;
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ptrspi_frame.sv
module ptrspi_frame #(
  parameter int DATA_W  = 24,
  parameter int ADDR_W  = 5,
  parameter int CHIP_W  = 3,
  parameter int CHIP_ID = 0,
  localparam int FRAME_W = DATA_W + ADDR_W + CHIP_W,
  localparam int CNT_W   = $clog2(FRAME_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_frame_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              bit_rise_i,
  input  logic              bit_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0]  CNT_SAT  = CNT_W'(FRAME_W + 1);
  localparam logic [CHIP_W-1:0] CHIP_VAL = CHIP_W'(CHIP_ID);

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (start_i) begin
      cnt_d = '0;
    end else if (in_frame_i && bit_rise_i) begin
      sr_d = {sr_q[FRAME_W-2:0], bit_i};
      if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign wr_en_o   = stop_i && (cnt_q == CNT_FULL) && (sr_q[CHIP_W-1:0] == CHIP_VAL);
  assign wr_addr_o = sr_q[CHIP_W +: ADDR_W];
  assign wr_data_o = sr_q[FRAME_W-1 -: DATA_W];
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/ptrspi_bank.sv
module ptrspi_bank #(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 5,
  localparam int NREG  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic load;
    assign load = wr_en_i && (wr_addr_i == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    regs_q[g] <= '0;
      else if (load) regs_q[g] <= wr_data_i;
    end
  end

  assign ptr_o     = regs_q[0][ADDR_W-1:0];
  assign rd_data_o = regs_q[ptr_o];
endmodule

// File: rtl/ptr_spi_slave.sv
module ptr_spi_slave
  import ptrspi_pkg::*;
#(
  parameter int DATA_W  = DEF_DATA_W,
  parameter int ADDR_W  = DEF_ADDR_W,
  parameter int CHIP_W  = DEF_CHIP_W,
  parameter int CHIP_ID = DEF_CHIP_ID,
  parameter int SYNC_N  = DEF_SYNC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic sdi_i,
  input  logic frame_en_i,
  input  logic lock_i,
  output logic sdo_o
);
  localparam int FRAME_W = DATA_W + ADDR_W + CHIP_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [SYN_W-1:0] SYN_RST = SYN_W'(1) << SYN_EN;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  logic [SYN_W-1:0] raw, syn;
  assign raw[SYN_SCLK] = sclk_i;
  assign raw[SYN_SDI]  = sdi_i;
  assign raw[SYN_EN]   = frame_en_i;

  ptrspi_sync #(.WIDTH(SYN_W), .STAGES(SYNC_N), .RST_VAL(SYN_RST)) i_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i(raw), .q_o(syn)
  );

  logic sclk_prev_q, en_prev_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sclk_prev_q <= 1'b0;
      en_prev_q   <= 1'b1;
    end else begin
      sclk_prev_q <= syn[SYN_SCLK];
      en_prev_q   <= syn[SYN_EN];
    end
  end

  logic in_frame, frame_start, frame_stop, bit_rise;
  assign in_frame    = !syn[SYN_EN];
  assign frame_start = en_prev_q && !syn[SYN_EN];
  assign frame_stop  = !en_prev_q && syn[SYN_EN];
  assign bit_rise    = syn[SYN_SCLK] && !sclk_prev_q;

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [CNT_W-1:0]  bit_cnt;

  ptrspi_frame #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CHIP_W(CHIP_W), .CHIP_ID(CHIP_ID)) i_frame (
    .clk(clk), .rst_n(rst_sync_n), .in_frame_i(in_frame), .start_i(frame_start),
    .stop_i(frame_stop), .bit_rise_i(bit_rise), .bit_i(syn[SYN_SDI]),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .cnt_o(bit_cnt)
  );

  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] rd_data;

  ptrspi_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_bank (
    .clk(clk), .rst_n(rst_sync_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ptr_o(ptr), .rd_data_o(rd_data)
  );

  // read shifter: loaded when a frame opens, zero-filled per serial edge
  logic [DATA_W-1:0] rd_sr_q, rd_sr_d;
  always_comb begin
    rd_sr_d = rd_sr_q;
    if (frame_start)                rd_sr_d = rd_data;
    else if (in_frame && bit_rise)  rd_sr_d = {rd_sr_q[DATA_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rd_sr_q <= '0;
    else             rd_sr_q <= rd_sr_d;
  end

  assign sdo_o = in_frame ? rd_sr_q[DATA_W-1] : lock_i;
endmodule

// File: rtl/ptrspi_chk.sv
module ptrspi_chk #(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 6,
  parameter int FRAME_W = 32
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              in_frame,
  input logic              frame_start,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [ADDR_W-1:0] ptr,
  input logic [DATA_W-1:0] rd_sr_q,
  input logic              sdo_o
);
  AST_START_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_start |=> (bit_cnt == '0)); // R2

  AST_WR_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |-> (!in_frame && $past(in_frame))); // R2

  AST_WR_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |-> (bit_cnt == CNT_W'(FRAME_W))); // R4

  AST_PTR_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(ptr) |-> $past(wr_en && (wr_addr == '0))); // R5

  AST_ZERO_TAIL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_frame && (bit_cnt >= CNT_W'(DATA_W))) |-> !sdo_o); // R6

  AST_IDLE_SR_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!in_frame && $past(!in_frame)) |-> $stable(rd_sr_q)); // R7
endmodule

bind ptr_spi_slave ptrspi_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FRAME_W(FRAME_W)
) i_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .in_frame(in_frame), .frame_start(frame_start),
  .wr_en(wr_en), .wr_addr(wr_addr), .bit_cnt(bit_cnt), .ptr(ptr),
  .rd_sr_q(rd_sr_q), .sdo_o(sdo_o)
);

// File: tb/test_ptr_spi_slave.sv
module test_ptr_spi_slave;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;

  logic clk = 1'b0;
  logic rst_n, sclk, sdi, en, lock, sdo;
  int   total = 0;
  int   bad   = 0;

  logic [23:0] mregs [NREG];
  logic [4:0]  mptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_spi_slave i_ptr_spi_slave (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi),
    .frame_en_i(en), .lock_i(lock), .sdo_o(sdo)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_check();
    lock = 1'b0; wait_clk(1); chk("R7 idle lock0", sdo, 1'b0);
    lock = 1'b1; wait_clk(1); chk("R7 idle lock1", sdo, 1'b1);
  endtask

  // one frame: writes {d,a,c}, nclk serial edges, checks every read bit
  task automatic run_frame(input logic [23:0] d, input logic [4:0] a,
                           input logic [2:0] c, input int nclk, input string tag);
    logic [31:0] w;
    logic [23:0] rexp;
    logic        ebit;
    w    = {d, a, c};
    rexp = mregs[mptr];
    en = 1'b0;
    wait_clk(6);
    for (int i = 0; i < nclk; i++) begin
      sdi  = (i < 32) ? w[31-i] : 1'b0;
      sclk = 1'b0;
      ebit = (i < 24) ? rexp[23-i] : 1'b0;
      lock = ~ebit;   // R7: lock must not leak into a frame
      wait_clk(4);
      chk(tag, sdo, ebit);
      sclk = 1'b1;
      wait_clk(4);
    end
    sclk = 1'b0;
    wait_clk(4);
    en = 1'b1;
    wait_clk(6);
    if (nclk == 32 && c == 3'b000) begin
      mregs[a] = d;
      if (a == 5'd0) mptr = d[4:0];
    end
    idle_check();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < NREG; i++) mregs[i] = '0;
    mptr = '0;
    rst_n = 1'b0; sclk = 1'b0; sdi = 1'b0; en = 1'b1; lock = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R1: reset state
    idle_check();
    run_frame(24'h000000, 5'd0, 3'b000, 32, "R1 reset reads zero");

    // R2: fill every register 1..31
    for (int i = 1; i < NREG; i++)
      run_frame(24'((i * 24'h0B3C5) ^ 24'hA50F00) | 24'(i), 5'(i), 3'b000, 32, "R2 write");

    // R5/R6: point at each register, read it back in the next frame
    for (int i = 1; i < NREG; i++) begin
      logic [23:0] pv;
      pv = {19'(i * 977), 5'(i)};
      run_frame(pv, 5'd0, 3'b000, 32, "R5 pointer write");
      run_frame(pv, 5'd0, 3'b000, 32, "R6 readback");
    end

    // R8: pointer persists over frames writing other registers
    run_frame(24'h123456, 5'd3, 3'b000, 32, "R8 persist a");
    run_frame(24'h654321, 5'd4, 3'b000, 32, "R8 persist b");
    run_frame(24'h0F0F0F, 5'd5, 3'b000, 32, "R8 persist c");

    // R9: frame writing reg0 still returns old pointer's register
    run_frame(24'h000004, 5'd0, 3'b000, 32, "R9 old pointer");
    run_frame(24'h000007, 5'd0, 3'b000, 32, "R9 new pointer a");
    run_frame(24'h000007, 5'd0, 3'b000, 32, "R9 new pointer b");

    // R3: nonzero chip codes are rejected
    for (int c = 1; c < 8; c++) begin
      run_frame(24'hFFFFE0 | 24'(c), 5'd0, 3'(c), 32, "R3 chip reject");
      run_frame(24'hDEAD00 | 24'(c), 5'd7, 3'(c), 32, "R3 chip reject");
    end
    run_frame(24'h000007, 5'd0, 3'b000, 32, "R3 verify");

    // R4: wrong frame lengths are discarded
    run_frame(24'h000002, 5'd0, 3'b000, 31, "R4 short");
    run_frame(24'h000002, 5'd0, 3'b000, 33, "R4 long");
    run_frame(24'h000002, 5'd0, 3'b000, 1,  "R4 one clock");
    run_frame(24'hABCDEF, 5'd7, 3'b000, 24, "R4 data only");
    run_frame(24'h000007, 5'd0, 3'b000, 32, "R4 verify");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule